// File: doc/BRIEF.md
# Halt and Wake-Up Controller

This block governs a small microcontroller's low-power halt state. A halt strobe from the core gates off the system oscillator and marks the power-down flag. While halted, the block watches four kinds of wake source: the external reset, the watchdog overflow, interrupt requests, and falling edges on the input port bits that are enabled for wake. It also records which interrupt requests were already raised when the halt began.

When a wake source is accepted, the block turns the oscillator back on. It then holds a busy indication for a fixed settling delay counted in system clocks. At the end of that delay it emits exactly one single-cycle decision: resume at the next instruction, take the interrupt, warm reset, or full reset.

Outside the halt state, the block maintains the power-down and time-out flags for the core. It also turns a watchdog overflow or an external reset into an immediate full reset request.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After `rst`, `osc_en` is 1 and `pd_flag`, `to_flag`, `halted`, `busy` and all four decision pulses are 0.
- R2: While running, a `halt_req` (with no `ext_rst` or `wdt_ovf` in the same cycle) causes the following at the next edge: `osc_en` goes to 0, `halted` goes to 1, `pd_flag` goes to 1 and `to_flag` goes to 0.
- R3: While running, `clr_wdt` clears both `pd_flag` and `to_flag` at the next edge.
- R4: While running, `wdt_ovf` gives a one-cycle `full_rst` pulse at the next edge and sets `to_flag`.
- R5: Bit i of `port_wake_en` enables wake on bit i of `port_in`. While halted, a falling edge on an enabled bit raises `busy` on the third edge after the input changes. A falling edge on a disabled bit leaves the block halted.
- R6: After a wake is accepted, `busy` is 1 and `osc_en` is 1 for exactly `WAKE_DELAY` cycles. On the next cycle `busy` is 0 and exactly one decision pulse is high for a single cycle.
- R7: A port wake ends with `resume_next`.
- R8: An interrupt wake ends with `take_irq` when that request's `irq_en` bit is 1 and `stack_full` is 0. Otherwise it ends with `resume_next`.
- R9: An interrupt request that was already high on the cycle `halt_req` was accepted cannot wake the block.
- R10: A watchdog overflow while halted sets `to_flag` at the wake edge, leaves `pd_flag` at 1, and ends with `warm_rst`.
- R11: An external reset clears `pd_flag` and `to_flag`. While running, it pulses `full_rst` at the next edge. While halted, it wakes the block and ends with `full_rst`.
- R12: Wake events and `halt_req` during the delay are ignored. When several sources arrive in the same cycle, the priority is external reset, then watchdog, then interrupt, then port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| ext_rst | input | 1 | External reset request, active high |
| halt_req | input | 1 | Halt strobe from the core |
| clr_wdt | input | 1 | Watchdog clear strobe |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| port_in | input | PORT_W | Input port pins (asynchronous) |
| port_wake_en | input | PORT_W | Per-bit wake enable for `port_in` |
| irq_req | input | NUM_IRQ | Interrupt request flags |
| irq_en | input | NUM_IRQ | Interrupt enables |
| stack_full | input | 1 | Call stack full |
| osc_en | output | 1 | System oscillator enable |
| halted | output | 1 | Block is in the halt state |
| busy | output | 1 | Wake-up delay in progress |
| resume_next | output | 1 | Decision: continue at the next instruction |
| take_irq | output | 1 | Decision: perform the interrupt response |
| warm_rst | output | 1 | Decision: reset only PC and SP |
| full_rst | output | 1 | Decision: full device initialization |
| pd_flag | output | 1 | Power-down flag |
| to_flag | output | 1 | Time-out flag |

## Verification
Strobes applied while running take effect at the first clock edge, as do interrupt, watchdog and reset wakes. A port wake appears only on the third edge, because of the two synchronizer stages and the previous-value register. The decision pulse arrives `WAKE_DELAY` edges after `busy` rises and lasts one cycle. The bench drives inputs and samples outputs on the falling clock edge. It counts those exact numbers of rising edges before each sample, and it checks one edge early (busy still low, or busy still high) as well as on the due edge.

// File: rtl/hw_pkg.sv
package hw_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_WAIT = 2'd2
  } hw_state_e;

  typedef enum logic [2:0] {
    DEC_NONE   = 3'd0,
    DEC_RESUME = 3'd1,
    DEC_IRQ    = 3'd2,
    DEC_WARM   = 3'd3,
    DEC_FULL   = 3'd4
  } hw_dec_e;
endpackage

// File: rtl/hw_port_edge.sv
module hw_port_edge #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pin,
  input  logic [PORT_W-1:0] wake_en,
  output logic [PORT_W-1:0] fall
);
  logic [PORT_W-1:0] sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    assign fall[i] = wake_en[i] & prev_q[i] & ~sync2_q[i];
  end

  // R5: an edge is reported only once for a single transition
  p_single_edge_r5: assert property (@(posedge clk) disable iff (rst)
    (fall != '0) |=> ((fall & $past(fall)) == '0));
endmodule

// File: rtl/hw_wake_arb.sv
module hw_wake_arb import hw_pkg::*; #(
  parameter int PORT_W  = 8,
  parameter int NUM_IRQ = 4
) (
  input  logic               ext_rst,
  input  logic               wdt_ovf,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_IRQ-1:0] pend_mask,
  input  logic               stack_full,
  input  logic [PORT_W-1:0]  port_fall,
  output logic               wake,
  output hw_dec_e            dec
);
  logic [NUM_IRQ-1:0] fresh_irq;

  assign fresh_irq = irq_req & ~pend_mask;

  always_comb begin
    dec = DEC_NONE;
    if (ext_rst)                                      dec = DEC_FULL;
    else if (wdt_ovf)                                 dec = DEC_WARM;
    else if (fresh_irq != '0) begin
      if (((fresh_irq & irq_en) != '0) && !stack_full) dec = DEC_IRQ;
      else                                            dec = DEC_RESUME;
    end
    else if (port_fall != '0)                         dec = DEC_RESUME;
  end

  assign wake = (dec != DEC_NONE);
endmodule

// File: rtl/hw_delay_cnt.sv
module hw_delay_cnt #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  // R6: count never passes the last step of the delay
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R6: counting restarts from zero each time the delay is left
  p_cnt_restart_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl import hw_pkg::*; #(
  parameter int PORT_W     = 8,
  parameter int NUM_IRQ    = 4,
  parameter int WAKE_DELAY = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_rst,
  input  logic               halt_req,
  input  logic               clr_wdt,
  input  logic               wdt_ovf,
  input  logic [PORT_W-1:0]  port_in,
  input  logic [PORT_W-1:0]  port_wake_en,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               stack_full,
  output logic               osc_en,
  output logic               halted,
  output logic               busy,
  output logic               resume_next,
  output logic               take_irq,
  output logic               warm_rst,
  output logic               full_rst,
  output logic               pd_flag,
  output logic               to_flag
);
  hw_state_e          state_q;
  hw_dec_e            dec_q, wake_dec;
  logic [NUM_IRQ-1:0] pend_q;
  logic [PORT_W-1:0]  port_fall;
  logic               wake, delay_done;
  logic               osc_q, pd_q, to_q;
  logic               resume_q, take_q, warm_q, full_q;

  hw_port_edge #(.PORT_W(PORT_W)) u_edge (
    .clk(clk), .rst(rst), .pin(port_in), .wake_en(port_wake_en), .fall(port_fall)
  );

  hw_wake_arb #(.PORT_W(PORT_W), .NUM_IRQ(NUM_IRQ)) u_arb (
    .ext_rst(ext_rst), .wdt_ovf(wdt_ovf), .irq_req(irq_req), .irq_en(irq_en),
    .pend_mask(pend_q), .stack_full(stack_full), .port_fall(port_fall),
    .wake(wake), .dec(wake_dec)
  );

  hw_delay_cnt #(.LIMIT(WAKE_DELAY)) u_delay (
    .clk(clk), .rst(rst), .run(state_q == ST_WAIT), .done(delay_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_RUN;
      dec_q    <= DEC_NONE;
      pend_q   <= '0;
      osc_q    <= 1'b1;
      pd_q     <= 1'b0;
      to_q     <= 1'b0;
      resume_q <= 1'b0;
      take_q   <= 1'b0;
      warm_q   <= 1'b0;
      full_q   <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      take_q   <= 1'b0;
      warm_q   <= 1'b0;
      full_q   <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          if (ext_rst) begin
            full_q <= 1'b1;
            pd_q   <= 1'b0;
            to_q   <= 1'b0;
          end else if (wdt_ovf) begin
            full_q <= 1'b1;
            to_q   <= 1'b1;
          end else if (halt_req) begin
            state_q <= ST_HALT;
            osc_q   <= 1'b0;
            pd_q    <= 1'b1;
            to_q    <= 1'b0;
            pend_q  <= irq_req;
          end else if (clr_wdt) begin
            pd_q <= 1'b0;
            to_q <= 1'b0;
          end
        end
        ST_HALT: begin
          if (wake) begin
            state_q <= ST_WAIT;
            osc_q   <= 1'b1;
            dec_q   <= wake_dec;
            if (wake_dec == DEC_WARM) to_q <= 1'b1;
            if (wake_dec == DEC_FULL) begin
              pd_q <= 1'b0;
              to_q <= 1'b0;
            end
          end
        end
        ST_WAIT: begin
          if (delay_done) begin
            state_q <= ST_RUN;
            dec_q   <= DEC_NONE;
            unique case (dec_q)
              DEC_RESUME: resume_q <= 1'b1;
              DEC_IRQ:    take_q   <= 1'b1;
              DEC_WARM:   warm_q   <= 1'b1;
              DEC_FULL:   full_q   <= 1'b1;
              default:    ;
            endcase
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign osc_en      = osc_q;
  assign halted      = (state_q == ST_HALT);
  assign busy        = (state_q == ST_WAIT);
  assign pd_flag     = pd_q;
  assign to_flag     = to_q;
  assign resume_next = resume_q;
  assign take_irq    = take_q;
  assign warm_rst    = warm_q;
  assign full_rst    = full_q;

  // R2: oscillator stays off for the whole halt
  p_halt_osc_off_r2: assert property (@(posedge clk) disable iff (rst)
    halted |-> !osc_en);
  // R2: halt entry marks power-down and clears time-out
  p_halt_flags_r2: assert property (@(posedge clk) disable iff (rst)
    (!halted && !busy && halt_req && !ext_rst && !wdt_ovf) |=> (halted && pd_flag && !to_flag));
  // R6: oscillator runs during the settling delay
  p_busy_osc_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> osc_en);
  // R12: never more than one decision at a time
  p_one_decision_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resume_next, take_irq, warm_rst, full_rst}));
  // R9: requests pending at entry cannot end the halt
  p_pending_no_wake_r9: assert property (@(posedge clk) disable iff (rst)
    (halted && !ext_rst && !wdt_ovf && ((irq_req & ~pend_q) == '0) && (port_fall == '0))
      |=> halted);
  // R10: a warm reset decision always carries the time-out flag
  p_warm_to_r10: assert property (@(posedge clk) disable iff (rst)
    warm_rst |-> to_flag);
  // R11: external reset while halted clears both flags
  p_ext_flags_r11: assert property (@(posedge clk) disable iff (rst)
    (halted && ext_rst) |=> (busy && !pd_flag && !to_flag));
endmodule

// File: tb/halt_wake_ctrl_bench.sv
module halt_wake_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PORT_W     = 8;
  localparam int NUM_IRQ    = 4;
  localparam int WAKE_DELAY = 1024;

  logic clk = 1'b0;
  logic rst, ext_rst, halt_req, clr_wdt, wdt_ovf, stack_full;
  logic [PORT_W-1:0]  port_in, port_wake_en;
  logic [NUM_IRQ-1:0] irq_req, irq_en;
  logic osc_en, halted, busy, resume_next, take_irq, warm_rst, full_rst, pd_flag, to_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_wake_ctrl #(.PORT_W(PORT_W), .NUM_IRQ(NUM_IRQ), .WAKE_DELAY(WAKE_DELAY)) u_halt_wake_ctrl (
    .clk(clk), .rst(rst), .ext_rst(ext_rst), .halt_req(halt_req), .clr_wdt(clr_wdt),
    .wdt_ovf(wdt_ovf), .port_in(port_in), .port_wake_en(port_wake_en),
    .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full),
    .osc_en(osc_en), .halted(halted), .busy(busy), .resume_next(resume_next),
    .take_irq(take_irq), .warm_rst(warm_rst), .full_rst(full_rst),
    .pd_flag(pd_flag), .to_flag(to_flag)
  );

  // pulse vector order: {full_rst, warm_rst, take_irq, resume_next}
  localparam logic [3:0] P_NONE = 4'b0000, P_RES = 4'b0001, P_IRQ = 4'b0010,
                         P_WARM = 4'b0100, P_FULL = 4'b1000;

  function automatic logic [3:0] pulses();
    return {full_rst, warm_rst, take_irq, resume_next};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic halt_now();
    halt_req = 1'b1;
    edges(1);
    halt_req = 1'b0;
    check("R2", "halted", 32'(halted), 1);
    check("R2", "osc_en", 32'(osc_en), 0);
  endtask

  // called one sample after busy rose
  task automatic finish_delay(string req, logic [3:0] exp);
    edges(WAKE_DELAY - 1);
    check("R6", "busy last delay cycle", 32'(busy), 1);
    check("R6", "osc_en during delay", 32'(osc_en), 1);
    check("R6", "no early decision", 32'(pulses()), 32'(P_NONE));
    edges(1);
    check("R6", "busy after delay", 32'(busy), 0);
    check(req, "decision", 32'(pulses()), 32'(exp));
    edges(1);
    check("R6", "decision one cycle", 32'(pulses()), 32'(P_NONE));
  endtask

  task automatic t_reset();
    check("R1", "osc_en", 32'(osc_en), 1);
    check("R1", "pd/to", 32'({pd_flag, to_flag}), 0);
    check("R1", "halted/busy", 32'({halted, busy}), 0);
    check("R1", "pulses", 32'(pulses()), 32'(P_NONE));
  endtask

  task automatic t_wdt_run_and_clr();
    wdt_ovf = 1'b1;
    edges(1);
    wdt_ovf = 1'b0;
    check("R4", "full_rst on overflow", 32'(pulses()), 32'(P_FULL));
    check("R4", "to set", 32'(to_flag), 1);
    edges(1);
    check("R4", "pulse single", 32'(pulses()), 32'(P_NONE));
    clr_wdt = 1'b1;
    edges(1);
    clr_wdt = 1'b0;
    check("R3", "to cleared", 32'(to_flag), 0);
  endtask

  task automatic t_port_disabled();
    halt_now();
    check("R2", "pd set", 32'(pd_flag), 1);
    check("R2", "to cleared", 32'(to_flag), 0);
    port_in[1] = 1'b0;           // bit 1 not enabled
    edges(6);
    check("R5", "disabled bit keeps halt", 32'({halted, busy}), 32'(2'b10));
    port_in[1] = 1'b1;
    edges(4);
    check("R5", "rising edge keeps halt", 32'({halted, busy}), 32'(2'b10));
  endtask

  task automatic t_port_wake();
    port_in[2] = 1'b0;           // enabled bit
    edges(2);
    check("R5", "busy not before third edge", 32'(busy), 0);
    edges(1);
    check("R5", "busy on third edge", 32'(busy), 1);
    wdt_ovf = 1'b1;
    irq_req = 4'b0001;
    ext_rst = 1'b1;
    halt_req = 1'b1;
    edges(1);
    wdt_ovf = 1'b0;
    irq_req = '0;
    ext_rst = 1'b0;
    halt_req = 1'b0;
    check("R12", "to unchanged by ignored overflow", 32'(to_flag), 0);
    check("R12", "pd unchanged by ignored reset", 32'(pd_flag), 1);
    edges(WAKE_DELAY - 2);
    check("R12", "still busy", 32'(busy), 1);
    edges(1);
    check("R7", "port wake resumes", 32'(pulses()), 32'(P_RES));
    check("R6", "running again", 32'({halted, busy}), 0);
    port_in[2] = 1'b1;
    edges(4);
    check("R3", "pd held after wake", 32'(pd_flag), 1);
    clr_wdt = 1'b1;
    edges(1);
    clr_wdt = 1'b0;
    check("R3", "pd cleared", 32'(pd_flag), 0);
  endtask

  task automatic t_irq(string tag, int bit_i, logic en, logic sf, logic [3:0] exp);
    halt_now();
    irq_en = en ? NUM_IRQ'(1 << bit_i) : '0;
    stack_full = sf;
    irq_req = NUM_IRQ'(1 << bit_i);
    edges(1);
    irq_req = '0;
    check("R8", {"busy ", tag}, 32'(busy), 1);
    finish_delay("R8", exp);
    irq_en = '0;
    stack_full = 1'b0;
  endtask

  task automatic t_irq_pending();
    irq_req = 4'b0100;
    edges(1);
    halt_now();
    edges(10);
    check("R9", "pending request no wake", 32'({halted, busy}), 32'(2'b10));
    irq_en = 4'b0001;
    irq_req = 4'b0101;
    edges(1);
    irq_req = '0;
    check("R9", "fresh request wakes", 32'(busy), 1);
    finish_delay("R8", P_IRQ);
    irq_en = '0;
  endtask

  task automatic t_wdt_halt();
    halt_now();
    wdt_ovf = 1'b1;
    irq_req = 4'b0010;           // lower priority, same cycle
    port_in[0] = 1'b0;
    edges(1);
    wdt_ovf = 1'b0;
    irq_req = '0;
    check("R10", "to set at wake", 32'(to_flag), 1);
    check("R10", "pd kept", 32'(pd_flag), 1);
    finish_delay("R10", P_WARM);
    port_in[0] = 1'b1;
    edges(4);
  endtask

  task automatic t_ext_halt();
    halt_now();
    ext_rst = 1'b1;
    wdt_ovf = 1'b1;
    edges(1);
    ext_rst = 1'b0;
    wdt_ovf = 1'b0;
    check("R11", "flags cleared at wake", 32'({pd_flag, to_flag}), 0);
    finish_delay("R12", P_FULL);
  endtask

  task automatic t_ext_run();
    wdt_ovf = 1'b1;
    edges(1);
    wdt_ovf = 1'b0;
    check("R4", "to set", 32'(to_flag), 1);
    ext_rst = 1'b1;
    edges(1);
    ext_rst = 1'b0;
    check("R11", "full_rst while running", 32'(pulses()), 32'(P_FULL));
    check("R11", "flags cleared", 32'({pd_flag, to_flag}), 0);
  endtask

  initial begin
    rst = 1'b1; ext_rst = 1'b0; halt_req = 1'b0; clr_wdt = 1'b0; wdt_ovf = 1'b0;
    stack_full = 1'b0; port_in = '1; port_wake_en = 8'h05; irq_req = '0; irq_en = '0;
    edges(3);
    rst = 1'b0;
    edges(4);
    t_reset();
    t_wdt_run_and_clr();
    t_port_disabled();
    t_port_wake();
    t_irq("enabled", 1, 1'b1, 1'b0, P_IRQ);
    t_irq("disabled", 3, 1'b0, 1'b0, P_RES);
    t_irq("stack full", 0, 1'b1, 1'b1, P_RES);
    t_irq_pending();
    t_wdt_halt();
    t_ext_halt();
    t_ext_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule